// File: doc/BRIEF.md
# Root Port PME Status Queue

This block holds the root control and root status registers of a PCI Express root port, as far as power-management events (PME) are concerned. A PME injection request carries the requester's bus, device and function numbers. If no PME is outstanding, that requester ID is latched into root status and the PME status flag is raised. If a PME is already outstanding, the new requester goes into a single-entry holding slot and the pending flag is set. When software acknowledges the current PME by writing 1 to the status flag, any held requester is promoted at once and the interrupt is raised again. Only when nothing is held does the status flag actually clear.

Hot-plug events enter on a separate input. When the function's power state asks for PME signalling, the hot-plug interrupt is not raised at once. The block marks it as deferred and injects a PME carrying the port's own requester ID. The deferred hot-plug interrupt is released when the last PME is acknowledged. Otherwise the hot-plug interrupt is requested directly. Both registers can be read and written through a simple config access port that carries a size field.

Top module: `pme_root_status`

## Requirements
- R1: While and after reset, root control and root status read zero and neither interrupt output is high.
- R2: Root status bits 15:8 hold the requester bus, bits 7:3 the device and bits 2:0 the function. Bit 16 is PME status, bit 17 is PME pending, and bits 31:18 read zero.
- R3: An injection while PME status is 0 loads the requester ID, sets PME status and leaves nothing held. It pulses `pme_irq_o` in the next cycle only if root control bit 3 (PME interrupt enable) is 1.
- R4: An injection while PME status is 1 sets PME pending and holds the requester, replacing any requester already held. The ID field and PME status stay unchanged and no PME interrupt is raised.
- R5: A status write with bit 16 set, made while a requester is held, loads the held ID, clears pending and empties the slot. PME status stays 1, and `pme_irq_o` pulses if PME interrupt enable is 1.
- R6: A status write with bit 16 set, made while nothing is held, clears PME status and keeps the ID field. A status write with bit 16 clear changes nothing.
- R7: A hot-plug event while `pme_req_pwr_i` is 1 marks a deferred hot-plug interrupt and injects a PME with `port_rid_i`. If an explicit injection occurs in the same cycle, that injection's requester is used instead. The deferred hot-plug interrupt pulses `hp_irq_o` only when the status write that clears PME status is made.
- R8: A hot-plug event while `pme_req_pwr_i` is 0 pulses `hp_irq_o` in the next cycle.
- R9: A write to root control (`cfg_sel_i`=0) takes effect only with `cfg_size_i`=1 (16-bit). A write to root status (`cfg_sel_i`=1) takes effect only with `cfg_size_i`=2 (32-bit). Sizes 0 and 3 change nothing.
- R10: When a status write and an injection fall in the same cycle, the write is applied first and the injection then sees the resulting state. A root control write in the same cycle sets the enable used for that cycle's interrupt decision.
- R11: Each interrupt output is high for exactly one cycle per triggering event. It is asserted in the cycle after the clock edge that applied the event.
- R12: `cfg_rdata_o` is a combinational read of the selected register, with root control zero-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Config write strobe |
| cfg_sel_i | input | 1 | Register select: 0 root control, 1 root status |
| cfg_size_i | input | 2 | Access size: 0 byte, 1 word, 2 dword, 3 reserved |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data of the selected register |
| pme_inj_i | input | 1 | PME injection request |
| pme_bus_i | input | 8 | Requester bus number |
| pme_dev_i | input | 5 | Requester device number |
| pme_fn_i | input | 3 | Requester function number |
| hp_evt_i | input | 1 | Hot-plug event |
| pme_req_pwr_i | input | 1 | Power state requests PME signalling |
| port_rid_i | input | 16 | Requester ID of this port, used for hot-plug PMEs |
| pme_irq_o | output | 1 | PME interrupt pulse |
| hp_irq_o | output | 1 | Hot-plug interrupt pulse |

## Verification
The bench targets a third PME that arrives while one is held, since a design that kept the oldest held requester would report a stale ID. It targets an acknowledge in the same cycle as an injection: getting the order wrong either drops the new PME or clears status under it. It targets a hot-plug deferred behind two stacked PMEs, where a design that released the deferred interrupt on the first acknowledge would fire it early. It also targets misdirected or wrong-size writes, and a design that honoured them would alter the enable or clear status without cause.

// File: rtl/pme_rs_pkg.sv
package pme_rs_pkg;
  parameter int unsigned BUS_W = 8;
  parameter int unsigned DEV_W = 5;
  parameter int unsigned FN_W  = 3;
  localparam int unsigned RID_W = BUS_W + DEV_W + FN_W;
  localparam int unsigned CTRL_W = 16;
  localparam int unsigned STAT_W = 32;
  localparam int unsigned ST_BIT = RID_W;      // PME status
  localparam int unsigned PD_BIT = RID_W + 1;  // PME pending
  localparam int unsigned EN_BIT = 3;          // PME interrupt enable in control

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_RSVD  = 2'd3
  } acc_size_e;

  function automatic logic [RID_W-1:0] pack_rid(input logic [BUS_W-1:0] bus,
                                                input logic [DEV_W-1:0] dev,
                                                input logic [FN_W-1:0]  fn);
    return {bus, dev, fn};
  endfunction
endpackage

// File: rtl/pme_rs_cfg_dec.sv
module pme_rs_cfg_dec
  import pme_rs_pkg::*;
(
  input  logic       wr_i,
  input  logic       sel_i,
  input  logic [1:0] size_i,
  input  logic       st_bit_i,
  output logic       ctrl_we_o,
  output logic       ack_o
);
  acc_size_e sz;
  assign sz        = acc_size_e'(size_i);
  assign ctrl_we_o = wr_i && !sel_i && (sz == SZ_WORD);
  assign ack_o     = wr_i &&  sel_i && (sz == SZ_DWORD) && st_bit_i;
endmodule

// File: rtl/pme_rs_ctrl_reg.sv
module pme_rs_ctrl_reg
  import pme_rs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [CTRL_W-1:0] ctrl_nxt_o
);
  logic [CTRL_W-1:0] ctrl_q;

  assign ctrl_nxt_o = we_i ? wdata_i : ctrl_q;
  assign ctrl_o     = ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_nxt_o;
  end
endmodule

// File: rtl/pme_rs_core.sv
module pme_rs_core
  import pme_rs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ack_i,
  input  logic              inj_i,
  input  logic [RID_W-1:0]  inj_rid_i,
  input  logic              hp_evt_i,
  input  logic              pwr_pme_i,
  input  logic [RID_W-1:0]  port_rid_i,
  input  logic              pme_en_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              pme_irq_o,
  output logic              hp_irq_o
);
  logic             st_q, st_d;
  logic             pd_q, pd_d;
  logic             def_q, def_d;
  logic [RID_W-1:0] id_q, id_d;
  logic [RID_W-1:0] hold_q, hold_d;
  logic             pme_fire, hp_fire;
  logic             any_inj;
  logic [RID_W-1:0] src_rid;

  assign any_inj = inj_i || (hp_evt_i && pwr_pme_i);
  assign src_rid = inj_i ? inj_rid_i : port_rid_i;

  always_comb begin
    st_d     = st_q;
    pd_d     = pd_q;
    def_d    = def_q;
    id_d     = id_q;
    hold_d   = hold_q;
    pme_fire = 1'b0;
    hp_fire  = 1'b0;
    // acknowledge is applied ahead of any same-cycle injection
    if (ack_i) begin
      if (pd_q) begin
        id_d     = hold_q;
        pd_d     = 1'b0;
        pme_fire = pme_en_i;
      end else begin
        st_d = 1'b0;
        if (def_q) begin
          def_d   = 1'b0;
          hp_fire = 1'b1;
        end
      end
    end
    if (hp_evt_i) begin
      if (pwr_pme_i) def_d   = 1'b1;
      else           hp_fire = 1'b1;
    end
    if (any_inj) begin
      if (st_d) begin
        pd_d   = 1'b1;
        hold_d = src_rid;
      end else begin
        id_d     = src_rid;
        st_d     = 1'b1;
        pd_d     = 1'b0;
        pme_fire = pme_en_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= 1'b0;
      pd_q      <= 1'b0;
      def_q     <= 1'b0;
      id_q      <= '0;
      hold_q    <= '0;
      pme_irq_o <= 1'b0;
      hp_irq_o  <= 1'b0;
    end else begin
      st_q      <= st_d;
      pd_q      <= pd_d;
      def_q     <= def_d;
      id_q      <= id_d;
      hold_q    <= hold_d;
      pme_irq_o <= pme_fire;
      hp_irq_o  <= hp_fire;
    end
  end

  assign stat_o = {{(STAT_W-RID_W-2){1'b0}}, pd_q, st_q, id_q};
endmodule

// File: rtl/pme_root_status.sv
module pme_root_status
  import pme_rs_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_wr_i,
  input  logic        cfg_sel_i,
  input  logic [1:0]  cfg_size_i,
  input  logic [31:0] cfg_wdata_i,
  output logic [31:0] cfg_rdata_o,
  input  logic        pme_inj_i,
  input  logic [7:0]  pme_bus_i,
  input  logic [4:0]  pme_dev_i,
  input  logic [2:0]  pme_fn_i,
  input  logic        hp_evt_i,
  input  logic        pme_req_pwr_i,
  input  logic [15:0] port_rid_i,
  output logic        pme_irq_o,
  output logic        hp_irq_o
);
  logic              ctrl_we, ack;
  logic [CTRL_W-1:0] ctrl_q, ctrl_nxt;
  logic [STAT_W-1:0] stat_q;

  pme_rs_cfg_dec i_dec (
    .wr_i      (cfg_wr_i),
    .sel_i     (cfg_sel_i),
    .size_i    (cfg_size_i),
    .st_bit_i  (cfg_wdata_i[ST_BIT]),
    .ctrl_we_o (ctrl_we),
    .ack_o     (ack)
  );

  pme_rs_ctrl_reg i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (ctrl_we),
    .wdata_i    (cfg_wdata_i[CTRL_W-1:0]),
    .ctrl_o     (ctrl_q),
    .ctrl_nxt_o (ctrl_nxt)
  );

  pme_rs_core i_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ack_i      (ack),
    .inj_i      (pme_inj_i),
    .inj_rid_i  (pack_rid(pme_bus_i, pme_dev_i, pme_fn_i)),
    .hp_evt_i   (hp_evt_i),
    .pwr_pme_i  (pme_req_pwr_i),
    .port_rid_i (port_rid_i),
    .pme_en_i   (ctrl_nxt[EN_BIT]),
    .stat_o     (stat_q),
    .pme_irq_o  (pme_irq_o),
    .hp_irq_o   (hp_irq_o)
  );

  assign cfg_rdata_o = cfg_sel_i ? stat_q : {{(32-CTRL_W){1'b0}}, ctrl_q};
endmodule

// File: rtl/pme_rs_chk.sv
module pme_rs_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cfg_wr_i,
  input logic        cfg_sel_i,
  input logic [1:0]  cfg_size_i,
  input logic [31:0] cfg_wdata_i,
  input logic        pme_inj_i,
  input logic        hp_evt_i,
  input logic        pme_req_pwr_i,
  input logic        pme_irq_o,
  input logic        hp_irq_o,
  input logic [15:0] ctrl_q,
  input logic [31:0] stat_q
);
  logic ack_seen, inj_seen;
  assign ack_seen = cfg_wr_i && cfg_sel_i && (cfg_size_i == 2'd2) && cfg_wdata_i[16];
  assign inj_seen = pme_inj_i || (hp_evt_i && pme_req_pwr_i);

  // R2
  pend_needs_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_q[17] |-> stat_q[16]);
  // R3
  irq_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pme_irq_o |-> ctrl_q[3]);
  // R4
  stack_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pme_inj_i && stat_q[16] && !ack_seen) |=> (stat_q[17] && stat_q[16] && !pme_irq_o));
  // R5
  promote_keeps_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_seen && stat_q[17] && !inj_seen) |=> (stat_q[16] && !stat_q[17]));
  // R6
  ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_seen && !stat_q[17] && !inj_seen) |=> !stat_q[16]);
  // R8
  direct_hp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hp_evt_i && !pme_req_pwr_i) |=> hp_irq_o);
  // R9
  ctrl_size_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_wr_i && !cfg_sel_i && cfg_size_i == 2'd1) |=> $stable(ctrl_q));
  // R2
  upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_q[31:18] == 14'd0);
endmodule

bind pme_root_status pme_rs_chk i_pme_rs_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cfg_wr_i      (cfg_wr_i),
  .cfg_sel_i     (cfg_sel_i),
  .cfg_size_i    (cfg_size_i),
  .cfg_wdata_i   (cfg_wdata_i),
  .pme_inj_i     (pme_inj_i),
  .hp_evt_i      (hp_evt_i),
  .pme_req_pwr_i (pme_req_pwr_i),
  .pme_irq_o     (pme_irq_o),
  .hp_irq_o      (hp_irq_o),
  .ctrl_q        (ctrl_q),
  .stat_q        (stat_q)
);

// File: tb/test_pme_root_status.sv
module test_pme_root_status;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0, cfg_sel = 1'b0;
  logic [1:0]  cfg_size = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        pme_inj = 1'b0;
  logic [7:0]  pme_bus = '0;
  logic [4:0]  pme_dev = '0;
  logic [2:0]  pme_fn = '0;
  logic        hp_evt = 1'b0, pme_req_pwr = 1'b0;
  logic [15:0] port_rid = 16'hA5C3;
  logic        pme_irq, hp_irq;

  int n_chk = 0, n_fail = 0;
  string tag = "R1";

  // reference model state
  int m_ctrl = 0, m_id = 0, m_hold = 0;
  bit m_st = 0, m_pd = 0, m_def = 0, m_pirq = 0, m_hirq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pme_root_status i_pme_root_status (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_wr_i(cfg_wr), .cfg_sel_i(cfg_sel), .cfg_size_i(cfg_size),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .pme_inj_i(pme_inj), .pme_bus_i(pme_bus), .pme_dev_i(pme_dev), .pme_fn_i(pme_fn),
    .hp_evt_i(hp_evt), .pme_req_pwr_i(pme_req_pwr), .port_rid_i(port_rid),
    .pme_irq_o(pme_irq), .hp_irq_o(hp_irq)
  );

  task automatic check(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int stat_val();
    return (int'(m_pd) << 17) | (int'(m_st) << 16) | m_id;
  endfunction

  // behavioural reference, evaluated on the inputs present at the edge
  task automatic model_edge();
    bit ack, en, inj;
    int rid;
    m_pirq = 0; m_hirq = 0;
    if (cfg_wr && !cfg_sel && cfg_size == 2'd1) m_ctrl = int'(cfg_wdata[15:0]);
    en  = m_ctrl[3];
    ack = cfg_wr && cfg_sel && cfg_size == 2'd2 && cfg_wdata[16];
    if (ack) begin
      if (m_pd) begin m_id = m_hold; m_pd = 0; m_pirq = en; end
      else begin
        m_st = 0;
        if (m_def) begin m_def = 0; m_hirq = 1; end
      end
    end
    if (hp_evt) begin
      if (pme_req_pwr) m_def = 1; else m_hirq = 1;
    end
    inj = pme_inj || (hp_evt && pme_req_pwr);
    rid = pme_inj ? ((int'(pme_bus) << 8) | (int'(pme_dev) << 3) | int'(pme_fn)) : int'(port_rid);
    if (inj) begin
      if (m_st) begin m_pd = 1; m_hold = rid; end
      else begin m_id = rid; m_st = 1; m_pd = 0; m_pirq = en; end
    end
  endtask

  task automatic compare_all();
    check(tag, "pme_irq", pme_irq, m_pirq);
    check(tag, "hp_irq", hp_irq, m_hirq);
    cfg_sel = 1'b0; #1;
    check(tag, "ctrl read", cfg_rdata, m_ctrl);
    cfg_sel = 1'b1; #1;
    check(tag, "status read", cfg_rdata, stat_val());
  endtask

  task automatic step(bit wr, bit sel, bit [1:0] sz, bit [31:0] wd,
                      bit inj, bit [7:0] b, bit [4:0] d, bit [2:0] f,
                      bit hp, bit pwr);
    cfg_wr = wr; cfg_sel = sel; cfg_size = sz; cfg_wdata = wd;
    pme_inj = inj; pme_bus = b; pme_dev = d; pme_fn = f;
    hp_evt = hp; pme_req_pwr = pwr;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    cfg_wr = 0; pme_inj = 0; hp_evt = 0;
    compare_all();
  endtask

  task automatic idle(); step(0,0,0,0, 0,0,0,0, 0,0); endtask
  task automatic ack_st(); step(1,1,2'd2,32'h0001_0000, 0,0,0,0, 0,0); endtask

  initial begin
    #(CLK_PERIOD*30000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R1 reset
    #(CLK_PERIOD*2);
    compare_all();
    @(negedge clk); rst_n = 1'b1;
    idle();

    // R9 wrong sizes ignored, then enable via word write
    tag = "R9";
    step(1,0,2'd0,32'h0000_FFFF, 0,0,0,0, 0,0);
    step(1,0,2'd2,32'h0000_FFFF, 0,0,0,0, 0,0);
    step(1,0,2'd3,32'h0000_FFFF, 0,0,0,0, 0,0);
    check("R9", "ctrl after bad sizes", m_ctrl, 0);
    step(1,0,2'd1,32'h0000_0008, 0,0,0,0, 0,0);

    // R2 R3 first PME with enable
    tag = "R3";
    step(0,0,0,0, 1,8'h12,5'h1B,3'h5, 0,0);
    check("R2", "packed id", cfg_rdata, 32'h0001_12DD);
    // R4 two stacked, newest held
    tag = "R4";
    step(0,0,0,0, 1,8'h34,5'h02,3'h1, 0,0);
    step(0,0,0,0, 1,8'h56,5'h1F,3'h7, 0,0);
    // R9 status ack with word size ignored
    tag = "R9";
    step(1,1,2'd1,32'h0001_0000, 0,0,0,0, 0,0);
    // R5 promote
    tag = "R5";
    ack_st();
    check("R5", "promoted id", cfg_rdata, 32'h0001_56FF);
    // R6 no-op write then clear
    tag = "R6";
    step(1,1,2'd2,32'h0000_0000, 0,0,0,0, 0,0);
    ack_st();
    check("R6", "status cleared", cfg_rdata, 32'h0000_56FF);
    // R10 ack + injection same cycle
    tag = "R10";
    step(0,0,0,0, 1,8'h01,5'h01,3'h1, 0,0);
    step(1,1,2'd2,32'h0001_0000, 1,8'h02,5'h02,3'h2, 0,0);
    step(1,0,2'd1,32'h0, 1,8'h03,5'h03,3'h3, 0,0);
    step(1,1,2'd2,32'h0001_0000, 1,8'h04,5'h04,3'h4, 0,0);
    ack_st(); ack_st(); idle();
    // R8 direct hot-plug
    tag = "R8";
    step(0,0,0,0, 0,0,0,0, 1,0);
    idle();
    // R7 deferred hot-plug behind stacked PMEs
    tag = "R7";
    step(1,0,2'd1,32'h8, 0,0,0,0, 0,0);
    step(0,0,0,0, 0,0,0,0, 1,1);
    check("R7", "port id loaded", cfg_rdata, 32'h0001_A5C3);
    step(0,0,0,0, 1,8'h77,5'h0A,3'h2, 0,0);
    ack_st();
    check("R7", "hp held on first ack", hp_irq, 0);
    ack_st();
    check("R7", "hp released on last ack", hp_irq, 1);
    // R11 pulse width
    tag = "R11";
    idle();
    check("R11", "hp pulse ends", hp_irq, 0);
    // R12 combinational read
    tag = "R12";
    cfg_sel = 1'b0; #1;
    check("R12", "ctrl zero-extended", cfg_rdata, 32'h8);

    // mixed random traffic against the model
    tag = "R11";
    for (int i = 0; i < 4000; i++) begin
      bit [2:0] k = 3'($urandom_range(0, 7));
      step(k < 3, k[0], 2'($urandom), (k == 1) ? 32'h0001_0000 : $urandom,
           ($urandom_range(0, 3) == 0), 8'($urandom), 5'($urandom), 3'($urandom),
           ($urandom_range(0, 7) == 0), 1'($urandom));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule